// File: doc/BRIEF.md
# Memory Tag Check Fault Policy Unit

This unit sits beside the load/store pipeline and decides, for every access, whether a tag comparison counts at all and what a mismatch turns into. Each access carries a valid strobe, a load/store direction, the privilege level it runs at (0 or 1) and a mismatch flag from the tag comparator. From those and from per-level control fields, the unit raises a one-cycle synchronous fault pulse or queues an asynchronous fault for the level of the access. Tag computation, memory access and exception delivery are handled elsewhere.

An asynchronous fault is first held as pending for its level. It reaches that level's sticky flag a fixed number of cycles later. An exception entry into level 1 can cut that wait short. When synchronization on entry is enabled, the entry pulse commits every pending fault, and every fault raised in the same cycle, into the sticky flags at once. The sticky flags hold until software clears them through a per-level clear strobe. A host-mode condition, which needs both host flags set, removes all checking from level 0 and leaves level 1 as it is.

Top module: `tag_fault_policy`

## Requirements
- R1: After reset, sync_fault, async_flag_l0 and async_flag_l1 are all 0.
- R2: The mode field of the accessing level selects the response to a checked access with tag_mismatch=1. Value 2'b00 ignores the mismatch, 2'b01 gives a synchronous fault and 2'b10 gives an asynchronous fault for that level. acc_priv=0 uses the lvl0_* controls and acc_priv=1 uses the lvl1_* controls.
- R3: With ASYM_EN=1, mode 2'b11 gives a synchronous fault for loads (acc_is_store=0) and an asynchronous fault for stores (acc_is_store=1).
- R4: With ASYM_EN=0, mode 2'b11 behaves exactly like 2'b00: no fault of either kind.
- R5: When the tag-enable bit of the accessing level is 0, the access raises no fault.
- R6: When the store-only bit of the accessing level is 1, loads raise no fault and stores are checked according to the mode.
- R7: When host_flag0 and host_flag1 are both 1, level-0 accesses raise no fault, and level-1 accesses behave as without host mode.
- R8: sync_fault is high for exactly the one cycle after the clock edge that samples a faulting access, and is never high without such an access.
- R9: Without an entry commit, an asynchronous fault sampled at edge N sets the level's sticky flag at edge N+DRAIN_CYCLES, and not earlier.
- R10: An entry_pulse sampled together with entry_sync_en=1 commits, at that edge, all pending asynchronous faults and any asynchronous fault sampled at the same edge into the flags. An entry_pulse with entry_sync_en=0 does not change the flags or the drain timing.
- R11: A sticky flag stays 1 until its own clear strobe (clr_l0 or clr_l1) is sampled high. If a commit and a clear reach the same flag at the same edge, the commit wins.
- R12: An access with tag_mismatch=0 raises no fault under any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one per access cycle |
| acc_is_store | input | 1 | 1 for a store, 0 for a load |
| acc_priv | input | 1 | Privilege level of the access (0 or 1) |
| tag_mismatch | input | 1 | Tag comparator reports a mismatch |
| lvl0_fault_mode | input | 2 | Fault response mode for level 0 |
| lvl0_tag_en | input | 1 | Tag checking enable for level 0 |
| lvl0_store_only | input | 1 | Level 0 checks stores only |
| lvl1_fault_mode | input | 2 | Fault response mode for level 1 |
| lvl1_tag_en | input | 1 | Tag checking enable for level 1 |
| lvl1_store_only | input | 1 | Level 1 checks stores only |
| host_flag0 | input | 1 | First host-mode condition |
| host_flag1 | input | 1 | Second host-mode condition |
| entry_sync_en | input | 1 | Commit pending faults on exception entry |
| entry_pulse | input | 1 | Exception entry into level 1 |
| clr_l0 | input | 1 | Clear the level-0 sticky flag |
| clr_l1 | input | 1 | Clear the level-1 sticky flag |
| sync_fault | output | 1 | Registered synchronous fault pulse |
| async_flag_l0 | output | 1 | Sticky asynchronous fault flag, level 0 |
| async_flag_l1 | output | 1 | Sticky asynchronous fault flag, level 1 |

## Verification
The hardest situation to reach from the ports is an entry commit that meets an asynchronous fault still inside its drain window, or one raised in the same cycle, because the drain would otherwise hide whether the commit took effect. The stimulus drives the faulting store and the entry pulse on the same falling edge, and in a second case one cycle apart. It samples the flag right after the entry edge, well before the drain could expire. A matching case with entry_sync_en low shows the flag staying clear until the full drain has elapsed, and a further case puts a clear strobe on the commit edge to show that the commit wins.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

  typedef enum logic [1:0] {
    CHK_IGNORE = 2'b00,
    CHK_SYNC   = 2'b01,
    CHK_ASYNC  = 2'b10,
    CHK_SPLIT  = 2'b11
  } chk_mode_e;

  localparam int unsigned NUM_LEVELS = 2;

  typedef struct packed {
    logic      tag_en;
    logic      store_only;
    chk_mode_e mode;
  } lvl_ctrl_t;

endpackage

// File: rtl/tfp_level_policy.sv
module tfp_level_policy
  import tfp_pkg::*;
#(
  parameter bit ASYM_EN    = 1'b1,
  parameter bit HOST_GATED = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sel,
  input  logic      is_store,
  input  logic      mismatch,
  input  lvl_ctrl_t ctrl,
  input  logic      host_mode,
  output logic      sync_hit,
  output logic      async_hit
);

  chk_mode_e eff_mode;
  logic      checked;
  logic      hit;

  always_comb begin
    eff_mode = ctrl.mode;
    if (!ASYM_EN && ctrl.mode == CHK_SPLIT) eff_mode = CHK_IGNORE;
  end

  assign checked = sel && ctrl.tag_en && (is_store || !ctrl.store_only)
                   && !(HOST_GATED && host_mode);
  assign hit = checked && mismatch;

  always_comb begin
    sync_hit  = 1'b0;
    async_hit = 1'b0;
    unique case (eff_mode)
      CHK_SYNC:  sync_hit  = hit;
      CHK_ASYNC: async_hit = hit;
      CHK_SPLIT: begin
        sync_hit  = hit && !is_store;
        async_hit = hit && is_store;
      end
      default: ;
    endcase
  end

  assert_tag_off_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !ctrl.tag_en |-> !(sync_hit || async_hit));

  assert_store_only_loads_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.store_only && !is_store) |-> !(sync_hit || async_hit));

  assert_no_mismatch_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !mismatch |-> !(sync_hit || async_hit));

  generate
    if (!ASYM_EN) begin : g_no_split
      assert_split_folded_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == CHK_SPLIT) |-> !(sync_hit || async_hit));
    end
  endgenerate

endmodule

// File: rtl/tfp_async_track.sv
module tfp_async_track #(
  parameter int unsigned DRAIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fault_in,
  input  logic entry_sync,
  input  logic clr,
  output logic flag
);

  localparam int unsigned CW = (DRAIN_CYCLES > 2) ? $clog2(DRAIN_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DRAIN_CYCLES - 1);

  logic          pend;
  logic [CW-1:0] cnt;
  logic          expire;
  logic          commit;

  assign expire = pend && (cnt == '0);
  assign commit = entry_sync ? (pend || fault_in) : expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      pend <= 1'b0;
      cnt  <= '0;
    end else begin
      if (commit)   flag <= 1'b1;
      else if (clr) flag <= 1'b0;

      if (entry_sync) begin
        pend <= 1'b0;
        cnt  <= '0;
      end else if (pend) begin
        if (expire) begin
          pend <= fault_in;
          cnt  <= LOAD;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (fault_in) begin
        pend <= 1'b1;
        cnt  <= LOAD;
      end
    end
  end

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  assert_entry_commit_R10: assert property (@(posedge clk) disable iff (rst)
    (entry_sync && fault_in) |=> flag);

  assert_flag_needs_source_R9: assert property (@(posedge clk) disable iff (rst)
    (!flag && !pend && !fault_in) |=> !flag);

endmodule

// File: rtl/tag_fault_policy.sv
module tag_fault_policy
  import tfp_pkg::*;
#(
  parameter bit          ASYM_EN      = 1'b1,
  parameter int unsigned DRAIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_valid,
  input  logic       acc_is_store,
  input  logic       acc_priv,
  input  logic       tag_mismatch,
  input  logic [1:0] lvl0_fault_mode,
  input  logic       lvl0_tag_en,
  input  logic       lvl0_store_only,
  input  logic [1:0] lvl1_fault_mode,
  input  logic       lvl1_tag_en,
  input  logic       lvl1_store_only,
  input  logic       host_flag0,
  input  logic       host_flag1,
  input  logic       entry_sync_en,
  input  logic       entry_pulse,
  input  logic       clr_l0,
  input  logic       clr_l1,
  output logic       sync_fault,
  output logic       async_flag_l0,
  output logic       async_flag_l1
);

  lvl_ctrl_t                 ctrl     [NUM_LEVELS];
  logic [NUM_LEVELS-1:0]     sync_hit;
  logic [NUM_LEVELS-1:0]     async_hit;
  logic [NUM_LEVELS-1:0]     clr_vec;
  logic [NUM_LEVELS-1:0]     flags;
  logic                      host_mode;
  logic                      entry_sync;

  assign host_mode  = host_flag0 && host_flag1;
  assign entry_sync = entry_pulse && entry_sync_en;
  assign clr_vec    = {clr_l1, clr_l0};

  assign ctrl[0] = '{tag_en: lvl0_tag_en, store_only: lvl0_store_only,
                     mode: chk_mode_e'(lvl0_fault_mode)};
  assign ctrl[1] = '{tag_en: lvl1_tag_en, store_only: lvl1_store_only,
                     mode: chk_mode_e'(lvl1_fault_mode)};

  generate
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      tfp_level_policy #(
        .ASYM_EN    (ASYM_EN),
        .HOST_GATED (g == 0)
      ) u_policy (
        .clk       (clk),
        .rst       (rst),
        .sel       (acc_valid && (acc_priv == 1'(g))),
        .is_store  (acc_is_store),
        .mismatch  (tag_mismatch),
        .ctrl      (ctrl[g]),
        .host_mode (host_mode),
        .sync_hit  (sync_hit[g]),
        .async_hit (async_hit[g])
      );

      tfp_async_track #(
        .DRAIN_CYCLES (DRAIN_CYCLES)
      ) u_track (
        .clk        (clk),
        .rst        (rst),
        .fault_in   (async_hit[g]),
        .entry_sync (entry_sync),
        .clr        (clr_vec[g]),
        .flag       (flags[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sync_fault <= 1'b0;
    else     sync_fault <= |sync_hit;
  end

  assign async_flag_l0 = flags[0];
  assign async_flag_l1 = flags[1];

  assert_sync_needs_access_R8: assert property (@(posedge clk) disable iff (rst)
    sync_fault |-> $past(acc_valid && tag_mismatch));

  assert_host_l0_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_priv && host_mode) |=> !sync_fault);

  assert_one_level_hit_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sync_hit | async_hit));

endmodule

// File: tb/tb_tag_fault_policy.sv
`timescale 1ns/1ps
module tb_tag_fault_policy;

  localparam int DRAIN = 4;
  localparam int NV    = 16;

  // {priv, store, mismatch, mode[1:0], tag_en, store_only, host, exp_sync, exp_f0, exp_f1}
  localparam logic [10:0] VEC [NV] = '{
    11'b1_0_1_00_1_0_0_0_0_0, // R2 ignore
    11'b1_0_1_01_1_0_0_1_0_0, // R2 sync level 1
    11'b1_1_1_10_1_0_0_0_0_1, // R2 async level 1
    11'b0_1_1_10_1_0_0_0_1_0, // R2 async level 0
    11'b0_0_1_01_1_0_0_1_0_0, // R2 sync level 0
    11'b1_0_1_11_1_0_0_1_0_0, // R3 split load
    11'b1_1_1_11_1_0_0_0_0_1, // R3 split store
    11'b0_1_1_11_1_0_0_0_1_0, // R3 split store level 0
    11'b1_0_1_01_0_0_0_0_0_0, // R5 level 1 disabled
    11'b0_1_1_10_0_0_0_0_0_0, // R5 level 0 disabled
    11'b1_0_1_01_1_1_0_0_0_0, // R6 load skipped
    11'b1_1_1_01_1_1_0_1_0_0, // R6 store checked
    11'b0_1_1_10_1_0_1_0_0_0, // R7 host level 0
    11'b1_1_1_10_1_0_1_0_0_1, // R7 host level 1 unaffected
    11'b0_0_1_01_1_0_1_0_0_0, // R7 host level 0 sync
    11'b1_0_0_01_1_0_0_0_0_0  // R12 no mismatch
  };

  logic clk = 1'b0;
  logic rst;
  logic acc_valid, acc_is_store, acc_priv, tag_mismatch;
  logic [1:0] l0_mode, l1_mode;
  logic l0_ten, l0_so, l1_ten, l1_so;
  logic hf0, hf1, sync_en, entry, clr0, clr1;
  logic sf, f0, f1, sf_na, f0_na, f1_na;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tag_fault_policy #(.ASYM_EN(1'b1), .DRAIN_CYCLES(DRAIN)) dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_is_store(acc_is_store),
    .acc_priv(acc_priv), .tag_mismatch(tag_mismatch),
    .lvl0_fault_mode(l0_mode), .lvl0_tag_en(l0_ten), .lvl0_store_only(l0_so),
    .lvl1_fault_mode(l1_mode), .lvl1_tag_en(l1_ten), .lvl1_store_only(l1_so),
    .host_flag0(hf0), .host_flag1(hf1), .entry_sync_en(sync_en), .entry_pulse(entry),
    .clr_l0(clr0), .clr_l1(clr1), .sync_fault(sf), .async_flag_l0(f0), .async_flag_l1(f1));

  tag_fault_policy #(.ASYM_EN(1'b0), .DRAIN_CYCLES(DRAIN)) dut_na (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_is_store(acc_is_store),
    .acc_priv(acc_priv), .tag_mismatch(tag_mismatch),
    .lvl0_fault_mode(l0_mode), .lvl0_tag_en(l0_ten), .lvl0_store_only(l0_so),
    .lvl1_fault_mode(l1_mode), .lvl1_tag_en(l1_ten), .lvl1_store_only(l1_so),
    .host_flag0(hf0), .host_flag1(hf1), .entry_sync_en(sync_en), .entry_pulse(entry),
    .clr_l0(clr0), .clr_l1(clr1), .sync_fault(sf_na), .async_flag_l0(f0_na), .async_flag_l1(f1_na));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // selected level gets the given controls; the other level is set to respond loudly
  task automatic set_ctrl(input logic priv, input logic [1:0] mode, input logic ten, input logic so);
    l0_mode = priv ? 2'b01 : mode; l0_ten = priv ? 1'b1 : ten; l0_so = priv ? 1'b0 : so;
    l1_mode = priv ? mode : 2'b01; l1_ten = priv ? ten : 1'b1; l1_so = priv ? so : 1'b0;
  endtask

  task automatic access(input logic priv, input logic st, input logic mm);
    acc_valid = 1'b1; acc_priv = priv; acc_is_store = st; tag_mismatch = mm;
  endtask

  task automatic quiet();
    acc_valid = 1'b0; tag_mismatch = 1'b0; entry = 1'b0; clr0 = 1'b0; clr1 = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr0 = 1'b1; clr1 = 1'b1;
    @(negedge clk); clr0 = 1'b0; clr1 = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst = 1'b1; quiet(); acc_is_store = 1'b0; acc_priv = 1'b0;
    set_ctrl(1'b0, 2'b00, 1'b0, 1'b0);
    hf0 = 1'b0; hf1 = 1'b0; sync_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sync_fault", sf, 0);
    chk("R1 flag0", f0, 0);
    chk("R1 flag1", f1, 0);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("vec%0d", i);
      @(negedge clk);
      set_ctrl(v[10], v[7:6], v[5], v[4]);
      hf0 = v[3]; hf1 = v[3];
      access(v[10], v[9], v[8]);
      @(negedge clk);
      acc_valid = 1'b0;
      chk({tag, " R8 sync pulse"}, sf, v[2]);
      repeat (DRAIN - 1) @(negedge clk);
      chk({tag, " R8 pulse ends"}, sf, 0);
      chk({tag, " R9 flag0 early"}, f0, 0);
      chk({tag, " R9 flag1 early"}, f1, 0);
      @(negedge clk);
      chk({tag, " R9 flag0"}, f0, v[1]);
      chk({tag, " R9 flag1"}, f1, v[0]);
      clear_all();
      chk({tag, " R11 cleared"}, int'(f0 | f1), 0);
    end
    hf0 = 1'b0; hf1 = 1'b0;

    // R4: split mode folded to ignore without the asymmetric option
    @(negedge clk); set_ctrl(1'b1, 2'b11, 1'b1, 1'b0); access(1'b1, 1'b0, 1'b1);
    @(negedge clk); acc_valid = 1'b0;
    chk("R4 load no sync", sf_na, 0);
    chk("R3 load sync ref", sf, 1);
    @(negedge clk); access(1'b1, 1'b1, 1'b1);
    @(negedge clk); acc_valid = 1'b0;
    repeat (DRAIN) @(negedge clk);
    chk("R4 store no flag", f1_na, 0);
    chk("R3 store flag ref", f1, 1);
    clear_all();

    // R10: fault and entry in the same cycle
    sync_en = 1'b1;
    @(negedge clk); set_ctrl(1'b1, 2'b10, 1'b1, 1'b0); access(1'b1, 1'b1, 1'b1); entry = 1'b1;
    @(negedge clk); quiet();
    chk("R10 same-cycle commit", f1, 1);
    clear_all();

    // R10: pending fault committed one cycle later
    @(negedge clk); set_ctrl(1'b0, 2'b10, 1'b1, 1'b0); access(1'b0, 1'b1, 1'b1);
    @(negedge clk); quiet(); entry = 1'b1;
    chk("R10 pending not yet", f0, 0);
    @(negedge clk); entry = 1'b0;
    chk("R10 pending committed", f0, 1);
    clear_all();

    // R10: entry without the enable leaves drain timing alone
    sync_en = 1'b0;
    @(negedge clk); access(1'b0, 1'b1, 1'b1);
    @(negedge clk); quiet(); entry = 1'b1;
    @(negedge clk); entry = 1'b0;
    chk("R10 disabled entry no commit", f0, 0);
    repeat (DRAIN - 2) @(negedge clk);
    chk("R10 disabled drain early", f0, 0);
    @(negedge clk);
    chk("R10 disabled drain done", f0, 1);
    clear_all();

    // R11: stickiness and per-level clear
    sync_en = 1'b1;
    @(negedge clk); set_ctrl(1'b1, 2'b10, 1'b1, 1'b0); l0_mode = 2'b10; access(1'b1, 1'b1, 1'b1);
    @(negedge clk); access(1'b0, 1'b1, 1'b1); entry = 1'b1;
    @(negedge clk); quiet();
    repeat (20) @(negedge clk);
    chk("R11 flag0 held", f0, 1);
    chk("R11 flag1 held", f1, 1);
    clr0 = 1'b1;
    @(negedge clk); clr0 = 1'b0;
    chk("R11 flag0 cleared", f0, 0);
    chk("R11 flag1 kept", f1, 1);
    clear_all();

    // R11: commit beats clear at the same edge
    @(negedge clk); access(1'b0, 1'b1, 1'b1); entry = 1'b1; clr0 = 1'b1;
    @(negedge clk); quiet();
    chk("R11 set beats clear", f0, 1);

    // R1: reset in mid-run clears a set flag
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset clears flag", f0, 0);
    chk("R1 reset clears sync", sf, 0);

    finish_run();
  end

endmodule